// File: doc/BRIEF.md
# Host-to-Controller Mailbox Interface

This block sits between a host processor bus and a local embedded controller and passes bytes in both directions through a pair of one-byte mailboxes. The host sees an active-low chip select, separate active-low read and write strobes, one address bit and an 8-bit data bus. The data bus is split into an input path, an output path and an output enable, so that a pad ring or a tristate wrapper can be placed around it. Host writes fill the input register, and host reads return either the output register or a status byte. The address bit chooses which one.

The status byte tells each side where the handshake stands. It has a full flag for each mailbox, two flags the local side can clear or toggle, and four user bits the local side loads. One of the two flags records the address bit of the most recent host write. A host can therefore tag a byte as a command or as data, and the local side can tell the two apart when it collects the byte.

Host strobes arrive asynchronously. They are resynchronised into the local clock domain, and a strobe takes effect only once, in the cycle after its release has been seen in the local clock domain. A long strobe therefore acts only once. Local-side operations are single-cycle pulses on the local clock.

Top module: `host_mailbox`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the input register, the output register, all four user status bits and the flags F1, F0, IBF and OBF to zero.
- R2: A host write is a period with `host_cs_n` and `host_wr_n` both low. When it ends, the byte that was on `host_din` is loaded into the input register, seen at `loc_in_data`, and IBF is set.
- R3: Each completed host write loads F1 with the `host_a0` value held during that write. If a local F1 clear or toggle takes effect in the same cycle as the host write, the host write decides F1.
- R4: During a host read, `host_a0` low places the output register on `host_dout`, and `host_a0` high places the status byte there. The status byte has bit 7..4 = user bits ST7..ST4, bit 3 = F1, bit 2 = F0, bit 1 = IBF and bit 0 = OBF. The same byte is always visible at `loc_status`.
- R5: A completed host read with `host_a0` low clears OBF. A host read with `host_a0` high leaves OBF unchanged.
- R6: A `loc_wr_out` pulse loads `loc_out_data` into the output register and sets OBF. If a clearing host read completes in the same cycle, the local load wins.
- R7: A `loc_rd_in` pulse clears IBF. If a host write completes in the same cycle, IBF stays set.
- R8: `loc_f0_clr` clears F0 and `loc_f0_tgl` inverts it. `loc_f1_clr` and `loc_f1_tgl` act the same way on F1. When clear and toggle of one flag are pulsed together, the clear wins, and operations on one flag leave the other flag unchanged.
- R9: The user bits ST7..ST4 change only on a `loc_wr_sts` pulse, which loads them from `loc_out_data[7:4]`. Output-register loads, host accesses and flag operations leave them unchanged.
- R10: `host_doe` is high only while `host_cs_n` and `host_rd_n` are both low. While the block is deselected or the host is writing, `host_doe` is low.
- R11: Each host strobe acts exactly once, in the cycle after its release is detected, however long it is held. While a write is held, IBF does not rise. While a read of the output register is held, OBF does not clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous reset, active high |
| host_cs_n | input | 1 | Host chip select, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_a0 | input | 1 | Host address bit: selects the output register or status on reads, and is recorded into F1 on writes |
| host_din | input | 8 | Host data bus, input direction |
| host_dout | output | 8 | Host data bus, output direction |
| host_doe | output | 1 | Host data bus output enable |
| loc_rd_in | input | 1 | Local pulse: input register collected, clears IBF |
| loc_in_data | output | 8 | Input register contents |
| loc_wr_out | input | 1 | Local pulse: load output register, set OBF |
| loc_wr_sts | input | 1 | Local pulse: load user status bits from upper nibble |
| loc_out_data | input | 8 | Local data word for output register and status loads |
| loc_f0_clr | input | 1 | Local pulse: clear F0 |
| loc_f0_tgl | input | 1 | Local pulse: toggle F0 |
| loc_f1_clr | input | 1 | Local pulse: clear F1 |
| loc_f1_tgl | input | 1 | Local pulse: toggle F1 |
| loc_status | output | 8 | Status byte as seen by the local side |

## Verification
Every piece of state in this block shows up at the ports. The input register is visible at `loc_in_data`, and the flags and user bits are visible at `loc_status` in every cycle. A corrupted flag or register can therefore be seen one clock after the operation that should have set it, or three clocks after a host strobe is released, once the two synchroniser stages and the edge stage have passed. A wrong choice of data source, or a wrong enable, shows on `host_dout` and `host_doe` while the read strobe is still held. Double action by a held strobe appears as a flag that changes during the hold rather than after it.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int DATA_W   = 8;
    localparam int USER_W   = 4;
    localparam int SYNC_LEN = 2;

    // architectural state of the mailbox
    typedef struct packed {
        logic [DATA_W-1:0] in_reg;
        logic [DATA_W-1:0] out_reg;
        logic [USER_W-1:0] user;
        logic              f1;
        logic              f0;
        logic              ibf;
        logic              obf;
    } mbx_state_t;

    // host-port tracking state
    typedef struct packed {
        logic              wr_prev;
        logic              rd_prev;
        logic [DATA_W-1:0] wdata;
        logic              wa0;
        logic              ra0;
    } port_state_t;
endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                assign chain_d[i] = d_in;
            end else begin : g_next
                assign chain_d[i] = chain_q[i-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= chain_d;
    end

    assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/mbx_host_port.sv
module mbx_host_port
    import mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_act,
    input  logic              rd_act,
    input  logic [DATA_W-1:0] din_s,
    input  logic              a0_s,
    output logic              wr_commit,
    output logic              rd_commit,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_a0,
    output logic              rd_a0
);
    port_state_t p_d, p_q;

    always_comb begin
        p_d         = p_q;
        p_d.wr_prev = wr_act;
        p_d.rd_prev = rd_act;
        // hold the latest bus values seen while a strobe is active
        if (wr_act) begin
            p_d.wdata = din_s;
            p_d.wa0   = a0_s;
        end
        if (rd_act) p_d.ra0 = a0_s;
    end

    always_ff @(posedge clk) begin
        if (rst) p_q <= '0;
        else     p_q <= p_d;
    end

    // release edge: active last cycle, inactive now
    assign wr_commit = p_q.wr_prev & ~wr_act;
    assign rd_commit = p_q.rd_prev & ~rd_act;
    assign wr_data   = p_q.wdata;
    assign wr_a0     = p_q.wa0;
    assign rd_a0     = p_q.ra0;
endmodule

// File: rtl/mbx_core.sv
module mbx_core
    import mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_commit,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_a0,
    input  logic              rd_commit,
    input  logic              rd_a0,
    input  logic              loc_rd_in,
    input  logic              loc_wr_out,
    input  logic              loc_wr_sts,
    input  logic [DATA_W-1:0] loc_out_data,
    input  logic              loc_f0_clr,
    input  logic              loc_f0_tgl,
    input  logic              loc_f1_clr,
    input  logic              loc_f1_tgl,
    output mbx_state_t        state
);
    mbx_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;

        // input mailbox: host fill beats local collect
        if (loc_rd_in) s_d.ibf = 1'b0;
        if (wr_commit) begin
            s_d.in_reg = wr_data;
            s_d.ibf    = 1'b1;
        end

        // output mailbox: local load beats host drain
        if (rd_commit && !rd_a0) s_d.obf = 1'b0;
        if (loc_wr_out) begin
            s_d.out_reg = loc_out_data;
            s_d.obf     = 1'b1;
        end

        if (loc_wr_sts) s_d.user = loc_out_data[DATA_W-1 -: USER_W];

        // flag 0: clear beats toggle
        if (loc_f0_clr)      s_d.f0 = 1'b0;
        else if (loc_f0_tgl) s_d.f0 = ~s_q.f0;

        // flag 1: host write beats clear beats toggle
        if (wr_commit)       s_d.f1 = wr_a0;
        else if (loc_f1_clr) s_d.f1 = 1'b0;
        else if (loc_f1_tgl) s_d.f1 = ~s_q.f1;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign state = s_q;
endmodule

// File: rtl/host_mailbox.sv
module host_mailbox
    import mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_cs_n,
    input  logic              host_rd_n,
    input  logic              host_wr_n,
    input  logic              host_a0,
    input  logic [DATA_W-1:0] host_din,
    output logic [DATA_W-1:0] host_dout,
    output logic              host_doe,
    input  logic              loc_rd_in,
    output logic [DATA_W-1:0] loc_in_data,
    input  logic              loc_wr_out,
    input  logic              loc_wr_sts,
    input  logic [DATA_W-1:0] loc_out_data,
    input  logic              loc_f0_clr,
    input  logic              loc_f0_tgl,
    input  logic              loc_f1_clr,
    input  logic              loc_f1_tgl,
    output logic [DATA_W-1:0] loc_status
);
    localparam int BUS_W = DATA_W + 3;

    logic [BUS_W-1:0]  raw_bus, sync_bus;
    logic              wr_act, rd_act, a0_s;
    logic [DATA_W-1:0] din_s;
    logic              wr_commit, rd_commit, wr_a0, rd_a0;
    logic [DATA_W-1:0] wr_data;
    mbx_state_t        state;
    logic [DATA_W-1:0] status_byte;

    // qualified strobes are resynchronised together with the bus they sample
    assign raw_bus = {~(host_cs_n | host_wr_n), ~(host_cs_n | host_rd_n), host_a0, host_din};

    mbx_sync #(.W(BUS_W), .STAGES(SYNC_LEN)) sync_i (
        .clk   (clk),
        .rst   (rst),
        .d_in  (raw_bus),
        .d_out (sync_bus)
    );

    assign wr_act = sync_bus[BUS_W-1];
    assign rd_act = sync_bus[BUS_W-2];
    assign a0_s   = sync_bus[DATA_W];
    assign din_s  = sync_bus[DATA_W-1:0];

    mbx_host_port port_i (
        .clk       (clk),
        .rst       (rst),
        .wr_act    (wr_act),
        .rd_act    (rd_act),
        .din_s     (din_s),
        .a0_s      (a0_s),
        .wr_commit (wr_commit),
        .rd_commit (rd_commit),
        .wr_data   (wr_data),
        .wr_a0     (wr_a0),
        .rd_a0     (rd_a0)
    );

    mbx_core core_i (
        .clk          (clk),
        .rst          (rst),
        .wr_commit    (wr_commit),
        .wr_data      (wr_data),
        .wr_a0        (wr_a0),
        .rd_commit    (rd_commit),
        .rd_a0        (rd_a0),
        .loc_rd_in    (loc_rd_in),
        .loc_wr_out   (loc_wr_out),
        .loc_wr_sts   (loc_wr_sts),
        .loc_out_data (loc_out_data),
        .loc_f0_clr   (loc_f0_clr),
        .loc_f0_tgl   (loc_f0_tgl),
        .loc_f1_clr   (loc_f1_clr),
        .loc_f1_tgl   (loc_f1_tgl),
        .state        (state)
    );

    assign status_byte = {state.user, state.f1, state.f0, state.ibf, state.obf};

    // bus side is asynchronous: drive follows the raw pins
    assign host_dout   = host_a0 ? status_byte : state.out_reg;
    assign host_doe    = ~(host_cs_n | host_rd_n);
    assign loc_in_data = state.in_reg;
    assign loc_status  = status_byte;
endmodule

// File: rtl/host_mailbox_chk.sv
module host_mailbox_chk
    import mbx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              host_cs_n,
    input logic              host_doe,
    input logic              wr_commit,
    input logic              wr_a0,
    input logic              rd_commit,
    input logic              rd_a0,
    input logic              loc_rd_in,
    input logic              loc_wr_out,
    input logic              loc_wr_sts,
    input logic [DATA_W-1:0] loc_out_data,
    input logic [DATA_W-1:0] loc_status,
    input logic [DATA_W-1:0] host_dout
);
    // R2
    ibf_set_chk: assert property (@(posedge clk) disable iff (rst)
        wr_commit |=> loc_status[1]);

    // R3
    f1_follows_a0_chk: assert property (@(posedge clk) disable iff (rst)
        wr_commit |=> (loc_status[3] == $past(wr_a0)));

    // R5
    obf_drain_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_commit && !rd_a0 && !loc_wr_out) |=> !loc_status[0]);

    // R6
    obf_fill_chk: assert property (@(posedge clk) disable iff (rst)
        loc_wr_out |=> loc_status[0]);

    // R7
    ibf_collect_chk: assert property (@(posedge clk) disable iff (rst)
        (loc_rd_in && !wr_commit) |=> !loc_status[1]);

    // R9
    user_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !loc_wr_sts |=> $stable(loc_status[7:4]));

    // R9
    user_load_chk: assert property (@(posedge clk) disable iff (rst)
        loc_wr_sts |=> (loc_status[7:4] == $past(loc_out_data[7:4])));

    // R10
    doe_select_chk: assert property (@(posedge clk) disable iff (rst)
        host_doe |-> !host_cs_n);

    // R11
    single_commit_chk: assert property (@(posedge clk) disable iff (rst)
        wr_commit |=> !wr_commit);

    // R11
    ibf_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(loc_status[1]) |-> $past(wr_commit));
endmodule

bind host_mailbox host_mailbox_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .host_cs_n    (host_cs_n),
    .host_doe     (host_doe),
    .wr_commit    (wr_commit),
    .wr_a0        (wr_a0),
    .rd_commit    (rd_commit),
    .rd_a0        (rd_a0),
    .loc_rd_in    (loc_rd_in),
    .loc_wr_out   (loc_wr_out),
    .loc_wr_sts   (loc_wr_sts),
    .loc_out_data (loc_out_data),
    .loc_status   (loc_status),
    .host_dout    (host_dout)
);

// File: tb/host_mailbox_tb_top.sv
module host_mailbox_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_cs_n = 1'b1, host_rd_n = 1'b1, host_wr_n = 1'b1, host_a0 = 1'b0;
    logic [7:0] host_din = 8'h00;
    logic [7:0] host_dout;
    logic       host_doe;
    logic       loc_rd_in = 1'b0, loc_wr_out = 1'b0, loc_wr_sts = 1'b0;
    logic [7:0] loc_out_data = 8'h00;
    logic       loc_f0_clr = 1'b0, loc_f0_tgl = 1'b0, loc_f1_clr = 1'b0, loc_f1_tgl = 1'b0;
    logic [7:0] loc_in_data, loc_status;

    int checks = 0;
    int errors = 0;

    // bench model
    logic [7:0] m_in = 8'h00, m_out = 8'h00;
    logic [3:0] m_user = 4'h0;
    logic       m_f1 = 1'b0, m_f0 = 1'b0, m_ibf = 1'b0, m_obf = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    host_mailbox dut_i (
        .clk(clk), .rst(rst),
        .host_cs_n(host_cs_n), .host_rd_n(host_rd_n), .host_wr_n(host_wr_n),
        .host_a0(host_a0), .host_din(host_din), .host_dout(host_dout), .host_doe(host_doe),
        .loc_rd_in(loc_rd_in), .loc_in_data(loc_in_data), .loc_wr_out(loc_wr_out),
        .loc_wr_sts(loc_wr_sts), .loc_out_data(loc_out_data),
        .loc_f0_clr(loc_f0_clr), .loc_f0_tgl(loc_f0_tgl),
        .loc_f1_clr(loc_f1_clr), .loc_f1_tgl(loc_f1_tgl),
        .loc_status(loc_status)
    );

    function automatic logic [7:0] exp_sts();
        return {m_user, m_f1, m_f0, m_ibf, m_obf};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic host_write(input logic a0, input logic [7:0] d);
        host_a0 = a0; host_din = d; host_cs_n = 1'b0; host_wr_n = 1'b0;
        #1 chk("R10 doe low during write", {7'd0, host_doe}, 8'h00);
        repeat (3) @(negedge clk);
        host_wr_n = 1'b1; host_cs_n = 1'b1;
        repeat (4) @(negedge clk);
        m_in = d; m_ibf = 1'b1; m_f1 = a0;
    endtask

    task automatic host_read(input logic a0, output logic [7:0] d, output logic oe);
        host_a0 = a0; host_cs_n = 1'b0; host_rd_n = 1'b0;
        #1 d = host_dout; oe = host_doe;
        repeat (3) @(negedge clk);
        host_rd_n = 1'b1; host_cs_n = 1'b1;
        repeat (4) @(negedge clk);
        if (!a0) m_obf = 1'b0;
    endtask

    task automatic loc_op(input logic rdin, input logic wrout, input logic wrsts,
                          input logic c0, input logic t0, input logic c1, input logic t1,
                          input logic [7:0] d);
        loc_rd_in = rdin; loc_wr_out = wrout; loc_wr_sts = wrsts;
        loc_f0_clr = c0; loc_f0_tgl = t0; loc_f1_clr = c1; loc_f1_tgl = t1;
        loc_out_data = d;
        @(negedge clk);
        loc_rd_in = 1'b0; loc_wr_out = 1'b0; loc_wr_sts = 1'b0;
        loc_f0_clr = 1'b0; loc_f0_tgl = 1'b0; loc_f1_clr = 1'b0; loc_f1_tgl = 1'b0;
        if (rdin) m_ibf = 1'b0;
        if (wrout) begin m_out = d; m_obf = 1'b1; end
        if (wrsts) m_user = d[7:4];
        if (c0) m_f0 = 1'b0; else if (t0) m_f0 = ~m_f0;
        if (c1) m_f1 = 1'b0; else if (t1) m_f1 = ~m_f1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        logic       oe;

        // dirty the state before reset
        repeat (3) @(negedge clk);
        rst = 1'b0;
        loc_op(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'hA5);
        host_write(1'b1, 8'h3C);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_in = 0; m_out = 0; m_user = 0; m_f1 = 0; m_f0 = 0; m_ibf = 0; m_obf = 0;
        chk("R1 status after reset", loc_status, 8'h00);
        chk("R1 input reg after reset", loc_in_data, 8'h00);
        chk("R10 doe idle", {7'd0, host_doe}, 8'h00);
        host_read(1'b0, rd, oe);
        chk("R1 output reg after reset", rd, 8'h00);

        // R10: read strobe without select drives nothing
        host_cs_n = 1'b1; host_rd_n = 1'b0;
        #1 chk("R10 doe deselected", {7'd0, host_doe}, 8'h00);
        @(negedge clk);
        host_rd_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R10 unselected read leaves state", loc_status, exp_sts());

        // R2/R3/R7 sweep over every byte, address bit taken from data bit 0
        for (int v = 0; v < 256; v++) begin
            host_write(v[0], v[7:0]);
            chk("R2 input reg", loc_in_data, m_in);
            chk("R2 R3 status after write", loc_status, exp_sts());
            loc_op(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
            chk("R7 ibf cleared", loc_status, exp_sts());
        end

        // R4/R5/R6 sweep on the output path
        for (int v = 0; v < 256; v += 7) begin
            loc_op(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, v[7:0]);
            chk("R6 obf set", loc_status, exp_sts());
            host_read(1'b1, rd, oe);
            chk("R4 status read", rd, exp_sts());
            chk("R10 doe during read", {7'd0, oe}, 8'h01);
            chk("R5 status read keeps obf", loc_status, exp_sts());
            host_read(1'b0, rd, oe);
            chk("R4 output reg read", rd, v[7:0]);
            chk("R5 obf cleared", loc_status, exp_sts());
        end

        // R9 sweep of user nibble with changing low bits
        for (int n = 0; n < 16; n++) begin
            loc_op(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, {n[3:0], ~n[3:0]});
            chk("R9 user load", loc_status, exp_sts());
            loc_op(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, {~n[3:0], n[3:0]});
            host_write(1'b0, 8'h5A);
            chk("R9 user held", loc_status, exp_sts());
            host_read(1'b0, rd, oe);
            chk("R9 user held after read", loc_status, exp_sts());
        end

        // R8 all combinations of the four flag pulses, applied twice
        for (int rep = 0; rep < 2; rep++) begin
            for (int k = 0; k < 16; k++) begin
                loc_op(1'b0, 1'b0, 1'b0, k[0], k[1], k[2], k[3], 8'h00);
                chk("R8 flag ops", loc_status, exp_sts());
            end
        end

        // R3 conflict: host write release lines up with a local F1 clear
        loc_op(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00);
        host_a0 = 1'b1; host_din = 8'hC3; host_cs_n = 1'b0; host_wr_n = 1'b0;
        repeat (3) @(negedge clk);
        host_wr_n = 1'b1; host_cs_n = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        loc_f1_clr = 1'b1; loc_f1_tgl = 1'b1;
        @(negedge clk);
        loc_f1_clr = 1'b0; loc_f1_tgl = 1'b0;
        m_in = 8'hC3; m_ibf = 1'b1; m_f1 = 1'b1;
        chk("R3 host write wins F1", loc_status, exp_sts());
        chk("R3 conflict data", loc_in_data, 8'hC3);

        // R11 long write: nothing happens until release
        loc_op(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
        host_a0 = 1'b0; host_din = 8'h77; host_cs_n = 1'b0; host_wr_n = 1'b0;
        repeat (20) @(negedge clk);
        chk("R11 ibf low during held write", loc_status, exp_sts());
        host_wr_n = 1'b1; host_cs_n = 1'b1;
        repeat (4) @(negedge clk);
        m_in = 8'h77; m_ibf = 1'b1; m_f1 = 1'b0;
        chk("R11 held write acts once", loc_status, exp_sts());
        loc_op(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
        repeat (6) @(negedge clk);
        chk("R11 no second write action", loc_status, exp_sts());

        // R11 long read of output reg
        loc_op(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h9E);
        host_a0 = 1'b0; host_cs_n = 1'b0; host_rd_n = 1'b0;
        repeat (20) @(negedge clk);
        chk("R11 obf held during read", loc_status, exp_sts());
        chk("R4 held read data", host_dout, 8'h9E);
        host_rd_n = 1'b1; host_cs_n = 1'b1;
        repeat (4) @(negedge clk);
        m_obf = 1'b0;
        chk("R11 read acts on release", loc_status, exp_sts());

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule